// File: doc/BRIEF.md
# Low-Power State Controller

This block steps a chip through five power states: off, deep sleep, sleep, wakeup and on. A chip power-down pin forces the off state, in which every register of the chip is held cleared. Software asks for sleep while the chip is running, and a one-bit mode picks light sleep (core domain kept powered but unclocked) or deep sleep (only the real-time-clock domain kept powered). A masked set of wakeup sources brings the chip back through a wakeup state. That state turns on the crystal oscillator and the PLL and waits until both report ready, or until a programmable timeout runs out.

Once on, the high-speed clock reaches only the blocks whose bit is set in a clock control vector. The CPU clock can also be parked by a wait-for-interrupt request, which does not leave the on state. All clock enables are registered on the falling edge of the clock, so they change only while the clock is low. A downstream AND gate therefore cannot glitch.

Top module: `lp_state_ctrl`

## Requirements
- R1: While `pd_n_i` is low the state becomes off (code 0) at the next rising edge and stays there. Off drives `clr_o` high and drops every power and clock enable. Reset also enters off.
- R2: In off, wakeup events and sleep requests have no effect. A high `pd_n_i` moves off to wakeup (code 3) at the next edge.
- R3: Deep sleep (code 1) powers only the RTC domain: `rtc_pwr_o`=1, `core_pwr_o`=0, oscillator and PLL off.
- R4: Light sleep (code 2) keeps the RTC and core domains powered, with the crystal oscillator and PLL disabled.
- R5: A sleep request is honoured only in on (code 4). It goes to deep sleep when `slp_deep_i`=1 and to light sleep when it is 0. In any other state it has no effect.
- R6: From either sleep state, a wakeup source moves to wakeup only when its bit in `wake_mask_i` is set. Bit 0 is MAC, bit 1 host, bit 2 RTC timer, bit 3 external interrupt. Masked events leave the state unchanged.
- R7: In wakeup, `xo_en_o` and `pll_en_o` are high. Wakeup moves to on at the edge where both `xo_rdy_i` and `pll_rdy_i` are high.
- R8: Without both ready inputs, wakeup moves to on after `wake_tmo_i`+1 cycles. The cycle counter starts at 0 on entry.
- R9: In on, `blk_clk_en_o` equals `clk_ctrl_i`. In every other state it is all zero.
- R10: In on, a `wfi_i` pulse clears `cpu_clk_en_o` until a pending interrupt with its enable bit set (`irq_i & irq_en_i` non-zero) releases it. An interrupt pending in the same cycle as `wfi_i` prevents the gating.
- R11: Clock enable outputs change only at falling clock edges and stay stable through each rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pd_n_i | input | 1 | Chip power-down pin, low forces off |
| slp_req_i | input | 1 | Software sleep request |
| slp_deep_i | input | 1 | Sleep mode: 1 deep, 0 light |
| wake_src_i | input | NSRC | Wakeup events (MAC, host, RTC timer, ext irq) |
| wake_mask_i | input | NSRC | Per-source wakeup enable |
| xo_rdy_i | input | 1 | Crystal oscillator ready |
| pll_rdy_i | input | 1 | PLL locked |
| wake_tmo_i | input | TW | Wakeup timeout in cycles |
| clk_ctrl_i | input | NBLK | Per-block clock enable control |
| wfi_i | input | 1 | CPU wait-for-interrupt request |
| irq_i | input | NIRQ | Pending interrupts |
| irq_en_i | input | NIRQ | Interrupt enables |
| state_o | output | 3 | State code: 0 off, 1 deep, 2 sleep, 3 wakeup, 4 on |
| clr_o | output | 1 | Global register clear |
| rtc_pwr_o | output | 1 | RTC domain power enable |
| core_pwr_o | output | 1 | Core domain power enable |
| xo_en_o | output | 1 | Crystal oscillator enable |
| pll_en_o | output | 1 | PLL enable |
| blk_clk_en_o | output | NBLK | Per-block gated clock enables |
| cpu_clk_en_o | output | 1 | CPU clock enable |

## Verification
The stimulus walks every state transition in turn. Wakeup exits are driven three ways: both ready inputs arriving at different cycles, ready arriving at once, and neither arriving so the timeout decides. This separates the ready handshake from the counter's off-by-one boundary, including a zero timeout. Sleep is requested in both modes and in states where it must be ignored. Wakeup events are sent masked, unmasked and while off, which shows the mask and the off-state blocking separately. The CPU gate is driven with a disabled interrupt, an enabled one, and an interrupt that coincides with the wait request. Each cycle the enables are also sampled just after the rising edge, to show they held since the previous falling edge.

// File: rtl/lp_pkg.sv
package lp_pkg;
  typedef enum logic [2:0] {
    ST_OFF   = 3'd0,
    ST_DEEP  = 3'd1,
    ST_SLEEP = 3'd2,
    ST_WAKE  = 3'd3,
    ST_ON    = 3'd4
  } lp_state_e;
endpackage

// File: rtl/lp_fsm.sv
module lp_fsm
  import lp_pkg::*;
#(
  parameter int TW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          pd_n_i,
  input  logic          slp_req_i,
  input  logic          slp_deep_i,
  input  logic          wake_hit_i,
  input  logic          xo_rdy_i,
  input  logic          pll_rdy_i,
  input  logic [TW-1:0] tmo_i,
  output lp_state_e     state_o
);
  lp_state_e state_q, state_d;
  logic [TW-1:0] cnt_q, cnt_d;
  logic wake_done;

  assign wake_done = (xo_rdy_i && pll_rdy_i) || (cnt_q == tmo_i);

  always_comb begin
    state_d = state_q;
    cnt_d   = '0;
    if (!pd_n_i) begin
      state_d = ST_OFF;
    end else begin
      unique case (state_q)
        ST_OFF:  state_d = ST_WAKE;
        ST_DEEP, ST_SLEEP: if (wake_hit_i) state_d = ST_WAKE;
        ST_WAKE: begin
          if (wake_done) state_d = ST_ON;
          else cnt_d = cnt_q + 1'b1;
        end
        ST_ON:   if (slp_req_i) state_d = slp_deep_i ? ST_DEEP : ST_SLEEP;
        default: state_d = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_OFF;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign state_o = state_q;
endmodule

// File: rtl/lp_cpu_wait.sv
module lp_cpu_wait #(
  parameter int NIRQ = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            is_on_i,
  input  logic            wfi_i,
  input  logic [NIRQ-1:0] irq_i,
  input  logic [NIRQ-1:0] irq_en_i,
  output logic            wait_o
);
  logic wait_q, irq_hit;
  assign irq_hit = |(irq_i & irq_en_i);

  // pending enabled irq wins over a new wait request
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wait_q <= 1'b0;
    else         wait_q <= is_on_i && !irq_hit && (wfi_i || wait_q);
  end

  assign wait_o = wait_q;
endmodule

// File: rtl/lp_clk_en.sv
module lp_clk_en #(
  parameter int NBLK = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            is_on_i,
  input  logic            cpu_run_i,
  input  logic [NBLK-1:0] ctrl_i,
  output logic [NBLK-1:0] blk_en_o,
  output logic            cpu_en_o
);
  // enables captured on falling edge: stable across the high phase
  for (genvar b = 0; b < NBLK; b++) begin : g_blk
    logic en_q;
    always_ff @(negedge clk_i or negedge rst_ni) begin
      if (!rst_ni) en_q <= 1'b0;
      else         en_q <= is_on_i && ctrl_i[b];
    end
    assign blk_en_o[b] = en_q;
  end

  logic cpu_q;
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cpu_q <= 1'b0;
    else         cpu_q <= is_on_i && cpu_run_i;
  end
  assign cpu_en_o = cpu_q;
endmodule

// File: rtl/lp_state_ctrl.sv
module lp_state_ctrl
  import lp_pkg::*;
#(
  parameter int NSRC = 4,
  parameter int NBLK = 8,
  parameter int NIRQ = 8,
  parameter int TW   = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            pd_n_i,
  input  logic            slp_req_i,
  input  logic            slp_deep_i,
  input  logic [NSRC-1:0] wake_src_i,
  input  logic [NSRC-1:0] wake_mask_i,
  input  logic            xo_rdy_i,
  input  logic            pll_rdy_i,
  input  logic [TW-1:0]   wake_tmo_i,
  input  logic [NBLK-1:0] clk_ctrl_i,
  input  logic            wfi_i,
  input  logic [NIRQ-1:0] irq_i,
  input  logic [NIRQ-1:0] irq_en_i,
  output logic [2:0]      state_o,
  output logic            clr_o,
  output logic            rtc_pwr_o,
  output logic            core_pwr_o,
  output logic            xo_en_o,
  output logic            pll_en_o,
  output logic [NBLK-1:0] blk_clk_en_o,
  output logic            cpu_clk_en_o
);
  lp_state_e st;
  logic wake_hit, is_on, cpu_wait;

  assign wake_hit = |(wake_src_i & wake_mask_i);

  lp_fsm #(.TW(TW)) i_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pd_n_i     (pd_n_i),
    .slp_req_i  (slp_req_i),
    .slp_deep_i (slp_deep_i),
    .wake_hit_i (wake_hit),
    .xo_rdy_i   (xo_rdy_i),
    .pll_rdy_i  (pll_rdy_i),
    .tmo_i      (wake_tmo_i),
    .state_o    (st)
  );

  assign is_on = (st == ST_ON);

  lp_cpu_wait #(.NIRQ(NIRQ)) i_cpu_wait (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .is_on_i  (is_on),
    .wfi_i    (wfi_i),
    .irq_i    (irq_i),
    .irq_en_i (irq_en_i),
    .wait_o   (cpu_wait)
  );

  lp_clk_en #(.NBLK(NBLK)) i_clk_en (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .is_on_i   (is_on),
    .cpu_run_i (!cpu_wait),
    .ctrl_i    (clk_ctrl_i),
    .blk_en_o  (blk_clk_en_o),
    .cpu_en_o  (cpu_clk_en_o)
  );

  assign state_o    = st;
  assign clr_o      = (st == ST_OFF);
  assign rtc_pwr_o  = (st != ST_OFF);
  assign core_pwr_o = (st == ST_SLEEP) || (st == ST_WAKE) || is_on;
  assign xo_en_o    = (st == ST_WAKE) || is_on;
  assign pll_en_o   = (st == ST_WAKE) || is_on;
endmodule

// File: rtl/lp_state_ctrl_chk.sv
module lp_state_ctrl_chk #(
  parameter int NSRC = 4,
  parameter int NBLK = 8,
  parameter int TW   = 8
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            pd_n_i,
  input logic            slp_req_i,
  input logic            slp_deep_i,
  input logic [NSRC-1:0] wake_src_i,
  input logic [NSRC-1:0] wake_mask_i,
  input logic            xo_rdy_i,
  input logic            pll_rdy_i,
  input logic [TW-1:0]   wake_tmo_i,
  input logic [2:0]      state_o,
  input logic            clr_o,
  input logic            core_pwr_o,
  input logic            xo_en_o,
  input logic [NBLK-1:0] blk_clk_en_o,
  input logic            cpu_clk_en_o
);
  logic [TW-1:0] wc;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              wc <= '0;
    else if (state_o == 3'd3 && pd_n_i) wc <= wc + 1'b1;
    else                      wc <= '0;
  end

  // R1
  pd_forces_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pd_n_i |=> (state_o == 3'd0) && clr_o);

  // R5
  sleep_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd4 && pd_n_i && slp_req_i) |=>
      (state_o == ($past(slp_deep_i) ? 3'd1 : 3'd2)));

  // R6
  masked_wake_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_o == 3'd1 || state_o == 3'd2) && pd_n_i &&
     !(|(wake_src_i & wake_mask_i))) |=> $stable(state_o));

  // R8
  wake_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd3 && pd_n_i && !(xo_rdy_i && pll_rdy_i) && wc != wake_tmo_i)
      |=> state_o == 3'd3);

  // R9
  blk_only_on_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|blk_clk_en_o || cpu_clk_en_o) |-> state_o == 3'd4);

  // R4
  xo_needs_core_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xo_en_o |-> core_pwr_o);
endmodule

bind lp_state_ctrl lp_state_ctrl_chk #(.NSRC(NSRC), .NBLK(NBLK), .TW(TW)) i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .pd_n_i       (pd_n_i),
  .slp_req_i    (slp_req_i),
  .slp_deep_i   (slp_deep_i),
  .wake_src_i   (wake_src_i),
  .wake_mask_i  (wake_mask_i),
  .xo_rdy_i     (xo_rdy_i),
  .pll_rdy_i    (pll_rdy_i),
  .wake_tmo_i   (wake_tmo_i),
  .state_o      (state_o),
  .clr_o        (clr_o),
  .core_pwr_o   (core_pwr_o),
  .xo_en_o      (xo_en_o),
  .blk_clk_en_o (blk_clk_en_o),
  .cpu_clk_en_o (cpu_clk_en_o)
);

// File: tb/test_lp_state_ctrl.sv
`timescale 1ns/1ps
module test_lp_state_ctrl;
  localparam int NSRC = 4, NBLK = 8, NIRQ = 8, TW = 8;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic pd_n_i = 1'b0, slp_req_i = 1'b0, slp_deep_i = 1'b0;
  logic [NSRC-1:0] wake_src_i = '0, wake_mask_i = '0;
  logic xo_rdy_i = 1'b0, pll_rdy_i = 1'b0;
  logic [TW-1:0] wake_tmo_i = 8'd5;
  logic [NBLK-1:0] clk_ctrl_i = '0;
  logic wfi_i = 1'b0;
  logic [NIRQ-1:0] irq_i = '0, irq_en_i = '0;
  logic [2:0] state_o;
  logic clr_o, rtc_pwr_o, core_pwr_o, xo_en_o, pll_en_o, cpu_clk_en_o;
  logic [NBLK-1:0] blk_clk_en_o;

  always #2.5 clk_i = ~clk_i;

  lp_state_ctrl #(.NSRC(NSRC), .NBLK(NBLK), .NIRQ(NIRQ), .TW(TW)) i_lp_state_ctrl (.*);

  int total = 0, bad = 0;
  int m_st = 0, m_cnt = 0;
  bit m_wait = 0;
  logic [NBLK-1:0] prev_blk = '0;
  logic prev_cpu = 1'b0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic model_step();
    bit irq_hit = |(irq_i & irq_en_i);
    m_wait = (m_st == 4) && !irq_hit && (wfi_i || m_wait);
    if (!pd_n_i) begin m_st = 0; m_cnt = 0; end
    else case (m_st)
      0: begin m_st = 3; m_cnt = 0; end
      1, 2: if (|(wake_src_i & wake_mask_i)) begin m_st = 3; m_cnt = 0; end
      3: if ((xo_rdy_i && pll_rdy_i) || m_cnt == int'(wake_tmo_i)) begin m_st = 4; m_cnt = 0; end
         else m_cnt++;
      4: if (slp_req_i) m_st = slp_deep_i ? 1 : 2;
      default: m_st = 0;
    endcase
  endtask

  task automatic compare();
    bit on = (m_st == 4);
    chk("R1/R2/R5/R6/R7/R8 state", state_o, m_st);
    chk("R1 clr", clr_o, m_st == 0);
    chk("R3 rtc_pwr", rtc_pwr_o, m_st != 0);
    chk("R3/R4 core_pwr", core_pwr_o, m_st >= 2);
    chk("R4/R7 xo_en", xo_en_o, m_st >= 3);
    chk("R4/R7 pll_en", pll_en_o, m_st >= 3);
    chk("R9 blk_en", blk_clk_en_o, on ? clk_ctrl_i : '0);
    chk("R10 cpu_en", cpu_clk_en_o, on && !m_wait);
  endtask

  task automatic cyc(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk_i);
      model_step();
      #1;
      // R11: nothing moved at the rising edge
      chk("R11 blk_en stable", blk_clk_en_o, prev_blk);
      chk("R11 cpu_en stable", cpu_clk_en_o, prev_cpu);
      #3;
      compare();
      prev_blk = blk_clk_en_o;
      prev_cpu = cpu_clk_en_o;
    end
  endtask

  initial begin
    #200000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #7;
    compare();                      // R1 reset state
    rst_ni = 1'b1;
    // R2: events and requests ignored while off
    wake_src_i = 4'hF; wake_mask_i = 4'hF; slp_req_i = 1'b1;
    cyc(3);
    wake_src_i = '0; slp_req_i = 1'b0;
    // R8: leave off, no ready, timeout 5
    pd_n_i = 1'b1; clk_ctrl_i = 8'hA5;
    cyc(9);
    // R9 patterns while on
    clk_ctrl_i = 8'h3C; cyc(2);
    clk_ctrl_i = 8'hFF; cyc(1);
    // R10: wfi, disabled irq, enabled irq
    wfi_i = 1'b1; cyc(1); wfi_i = 1'b0; cyc(2);
    irq_i = 8'h01; cyc(2);
    irq_en_i = 8'h01; cyc(2);
    wfi_i = 1'b1; cyc(2);           // coincident irq prevents gating
    wfi_i = 1'b0; irq_i = '0; cyc(1);
    wfi_i = 1'b1; cyc(1); wfi_i = 1'b0; cyc(1);
    // R5: light sleep while cpu parked
    slp_req_i = 1'b1; slp_deep_i = 1'b0; cyc(1);
    cyc(2);                         // R5 request ignored in sleep
    slp_req_i = 1'b0;
    // R6: masked events
    wake_mask_i = 4'b0001; wake_src_i = 4'b1110; cyc(3);
    // R7: host unmasked, ready arrives staggered
    wake_mask_i = 4'b0010; wake_src_i = 4'b0010; wake_tmo_i = 8'd40;
    cyc(1); wake_src_i = '0;
    slp_req_i = 1'b1; slp_deep_i = 1'b1; // R5 ignored in wakeup
    cyc(2); xo_rdy_i = 1'b1; cyc(2); slp_req_i = 1'b0;
    pll_rdy_i = 1'b1; cyc(2);
    // R3: deep sleep, RTC timer wakes, ready at once
    slp_req_i = 1'b1; slp_deep_i = 1'b1; cyc(1); slp_req_i = 1'b0;
    cyc(2);
    wake_mask_i = 4'b0100; wake_src_i = 4'b0100; cyc(1); wake_src_i = '0;
    cyc(2);
    // R8: zero timeout
    xo_rdy_i = 1'b0; pll_rdy_i = 1'b0; wake_tmo_i = 8'd0;
    slp_req_i = 1'b1; slp_deep_i = 1'b0; cyc(1); slp_req_i = 1'b0;
    wake_mask_i = 4'b1000; wake_src_i = 4'b1000; cyc(1); wake_src_i = '0;
    cyc(3);
    // R1: power-down from on
    pd_n_i = 1'b0; cyc(3);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule